// File: doc/BRIEF.md
# Infrared Transceiver Port With Background Adaptation

This block is a single byte-wide control and status register for an infrared link. One writable bit drives the transmit LED directly. A two-bit enable field arms the receiver. A read-only bit reports the state of a digital IR detector, and it is active-low: it reads 0 while infrared is being seen.

The detector input passes through a synchroniser and then an adaptation stage. That stage counts how many consecutive cycles the detector has been active. When the count reaches a programmed limit, the stage treats the steady level as ambient light and stops reporting it. Short on/off pulse trains therefore reach software, and a long unbroken level is dropped.

Software writes the register to send and receive. It writes 00h afterwards to put the port back into its idle, low-power state.

Top module: `ir_port`

## Requirements
- R1: After reset the register reads 3Eh (enable field 0, bits 5..2 set, receive bit 1, transmit bit 0) and led_out is 0.
- R2: A write stores wr_data[0] as the transmit bit. It reads back at bit 0, and led_out equals it from the clock edge that takes the write.
- R3: A write stores wr_data[7:6] as the receive-enable field, which reads back at bits 7..6. Bits 5..2 always read 1, whatever was written to them.
- R4: Bit 1 cannot be written. Writing it as 0 leaves the read value of bit 1 unchanged.
- R5: While the enable field is anything other than 3, bit 1 reads 1 whatever ir_in does.
- R6: While the enable field is 3 and ir_in is 1 (IR present), bit 1 reads 0. The input passes through SYNC_STAGES registers first, so a change on ir_in appears on bit 1 SYNC_STAGES clock edges later.
- R7: If ir_in stays 1 without a break, bit 1 reads 0 for exactly ADAPT_CYCLES cycles. It then reads 1 until the synchronised input returns to 0.
- R8: A single synchronised 0 sample clears the adaptation count. A pulse train whose on-time is shorter than ADAPT_CYCLES therefore shows up as 0 on bit 1 in every pulse.
- R9: Writing 00h turns the LED off on the next edge and disables the receiver, so bit 1 then reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current register read value |
| led_out | output | 1 | IR LED drive, 1 = on |
| ir_in | input | 1 | Digital detector output, 1 = IR seen (asynchronous) |

## Verification
The hardest state to reach is the edge of adaptation: the exact cycle in which a steady level is first suppressed, together with the case where a single low sample arrives just before that point and restarts the count. The bench uses a small adaptation limit. It holds ir_in high for longer than the limit and counts the cycles that bit 1 reads 0. It also sends a 10-on/17-off pulse train, and random runs of lengths on both sides of the limit, while a reference model tracks the expected count every cycle.

// File: rtl/ir_pkg.sv
// Shared definitions for the infrared port.
// Assumes: the register layout below is fixed, because software decodes it.
package ir_pkg;
    typedef struct packed {
        logic [1:0] rx_en;   // receive enable field, bits 7..6
        logic       tx;      // LED drive, bit 0
    } ir_ctrl_t;

    localparam logic [1:0] RX_ARMED = 2'b11;
    localparam logic [3:0] PAD_ONES = 4'hF;
endpackage

// File: rtl/ir_sync.sv
// Multi-flop synchroniser for the asynchronous detector input.
// Assumes: STAGES >= 2; the output lags the input by STAGES edges.
module ir_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] chain;

    // Shift the input along the chain; clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_in};
    end

    assign q_out = chain[STAGES-1];
endmodule

// File: rtl/ir_adapt.sv
// Adaptation stage: passes the synchronised level through until it has
// stayed active for LIMIT cycles, then treats it as ambient light.
// Assumes: sync_in is already synchronous to clk; LIMIT >= 1.
module ir_adapt #(
    parameter int LIMIT = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic detected
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] run_cnt;

    // Count consecutive active samples, saturating; any idle sample clears.
    always_ff @(posedge clk) begin
        if (!rst_n)              run_cnt <= '0;
        else if (!sync_in)       run_cnt <= '0;
        else if (run_cnt != LIM) run_cnt <= run_cnt + 1'b1;
    end

    assign detected = sync_in && (run_cnt < LIM);

    // R7
    cnt_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= LIM);

    // R8
    idle_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_in |=> run_cnt == '0);

    // R7
    saturated_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt == LIM) |-> !detected);
endmodule

// File: rtl/ir_port.sv
// Infrared port register: LED drive bit, receive-enable field and an
// active-low receive bit fed by a synchronised, background-adapting detector.
// Assumes: a single register, written whenever wr_en is high; reads are
// combinational from the stored state.
module ir_port
    import ir_pkg::*;
#(
    parameter int ADAPT_CYCLES = 25000,  // about 200 us at 125 MHz
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    output logic       led_out,
    input  logic       ir_in
);
    ir_ctrl_t ctrl;
    logic     ir_sync_q;
    logic     ir_seen;
    logic     rx_bit_n;

    // Hold the writable fields; bits 5..1 of a write are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)     ctrl <= '{rx_en: 2'b00, tx: 1'b0};
        else if (wr_en) ctrl <= '{rx_en: wr_data[7:6], tx: wr_data[0]};
    end

    ir_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (ir_in),
        .q_out (ir_sync_q)
    );

    ir_adapt #(.LIMIT(ADAPT_CYCLES)) u_adapt (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_in  (ir_sync_q),
        .detected (ir_seen)
    );

    // Active-low receive bit, forced idle unless the receiver is armed.
    always_comb begin
        rx_bit_n = !((ctrl.rx_en == RX_ARMED) && ir_seen);
    end

    assign rd_data = {ctrl.rx_en, PAD_ONES, rx_bit_n, ctrl.tx};
    assign led_out = ctrl.tx;

    // R2
    led_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> led_out == $past(wr_data[0]));

    // R5
    disarmed_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7:6] != RX_ARMED) |-> rd_data[1]);

    // R9
    zero_write_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data == 8'h00) |=> (!led_out && rd_data[1]));

    // R3
    enable_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[7:6] == $past(wr_data[7:6]));
endmodule

// File: tb/ir_port_test.sv
module ir_port_test;
    localparam int L  = 40;
    localparam int SS = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       ir_in = 1'b0;
    logic [7:0] rd_data;
    logic       led_out;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic       m_tx = 0;
    logic [1:0] m_en = 0;
    logic [SS-1:0] m_sh = 0;
    int         m_run = 0;

    ir_port #(.ADAPT_CYCLES(L), .SYNC_STAGES(SS)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .led_out(led_out), .ir_in(ir_in)
    );

    always #4 clk = ~clk;

    // Model of the requirements, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_tx = 0; m_en = 0; m_sh = 0; m_run = 0;
        end else begin
            if (wr_en) begin m_tx = wr_data[0]; m_en = wr_data[7:6]; end
            if (!m_sh[SS-1]) m_run = 0;
            else if (m_run < L) m_run = m_run + 1;
            m_sh = {m_sh[SS-2:0], ir_in};
        end
    end

    function automatic logic [7:0] exp_rd();
        logic rx;
        rx = !(m_en == 2'b11 && m_sh[SS-1] && m_run < L);
        return {m_en, 4'hF, rx, m_tx};
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic step(string req);
        tick();
        chk(req, rd_data, exp_rd());
        chk(req, {7'd0, led_out}, {7'd0, m_tx});
    endtask

    task automatic wr(logic [7:0] d, string req);
        wr_en = 1'b1; wr_data = d;
        step(req);
        wr_en = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int low_cnt;
        int run_len;
        void'($urandom(32'd1234));
        repeat (3) tick();
        rst_n = 1'b1;
        // R1 reset value
        chk("R1", rd_data, 8'h3E);
        chk("R1", {7'd0, led_out}, 8'h00);

        // R2 transmit bit and LED
        wr(8'h01, "R2");
        chk("R2", {7'd0, led_out}, 8'h01);
        // R3 enable field readback, pad bits ignored
        wr(8'h80, "R3");
        chk("R3", rd_data, 8'hBE);
        // R4 writing bit 1 as 0 has no effect
        wr(8'h00, "R4");
        chk("R4", {7'd0, rd_data[1]}, 8'h01);

        // R5 input high while disarmed
        ir_in = 1'b1;
        repeat (5) step("R5");
        chk("R5", {7'd0, rd_data[1]}, 8'h01);
        ir_in = 1'b0;
        repeat (3) step("R5");

        // R6 latency: armed, then raise input
        wr(8'hC0, "R6");
        ir_in = 1'b1;
        step("R6");
        chk("R6", {7'd0, rd_data[1]}, 8'h01);
        step("R6");
        chk("R6", {7'd0, rd_data[1]}, 8'h00);
        // R7 count cycles at 0 under a steady level
        low_cnt = 1;
        repeat (L + 10) begin
            step("R7");
            if (!rd_data[1]) low_cnt++;
        end
        chk("R7", 8'(low_cnt), 8'(L));
        ir_in = 1'b0;
        repeat (4) step("R7");

        // R8 pulse train 10 on / 17 off is never suppressed
        for (int p = 0; p < 6; p++) begin
            low_cnt = 0;
            ir_in = 1'b1;
            repeat (10) begin step("R8"); if (!rd_data[1]) low_cnt++; end
            ir_in = 1'b0;
            repeat (17) begin step("R8"); if (!rd_data[1]) low_cnt++; end
            chk("R8", 8'(low_cnt), 8'd10);
        end
        // R8 one low sample just before saturation restarts the count
        ir_in = 1'b1;
        repeat (L - 3) step("R8");
        ir_in = 1'b0;
        step("R8");
        ir_in = 1'b1;
        repeat (SS + 5) step("R8");
        chk("R8", {7'd0, rd_data[1]}, 8'h00);

        // R9 writing 00h idles the port
        wr(8'hC1, "R9");
        wr(8'h00, "R9");
        chk("R9", {7'd0, led_out}, 8'h00);
        chk("R9", {7'd0, rd_data[1]}, 8'h01);

        // random mix of runs and writes (R2 R3 R5 R6 R7 R8)
        for (int i = 0; i < 120; i++) begin
            run_len = 1 + ($urandom % (L + 20));
            ir_in = ~ir_in;
            for (int j = 0; j < run_len; j++) begin
                if (($urandom % 16) == 0) begin
                    wr_en = 1'b1;
                    wr_data = $urandom;
                    if (($urandom % 4) != 0) wr_data[7:6] = 2'b11;
                end
                step("R7");
                wr_en = 1'b0;
            end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule